// File: doc/BRIEF.md
# Dual-Mode Baud-Rate Timing Detector

This block measures the timing error of a baud-rate sampled PAM4 receiver. It receives one equalized sample per symbol together with a slicer reference, which is the amplitude of the outer signal level. Each sample is sliced twice in the same cycle. One slicer makes a four-level decision and the other makes a two-level decision. The block then forms the Mueller-Müller timing error from the current symbol and the previous one. A loop filter downstream integrates this phase word to steer the sampling clock.

A mode input is captured with every symbol. It selects which slicer feeds the timing computation. Two-level slicing folds the inner levels onto the outer ones. This removes the false stable points that four-level slicing produces near the symbol edges, at the cost of a lower detector gain. The usual sequence is to acquire lock in two-level mode and then switch to four-level mode. The four-level decision and error are always exported for an equalizer adaptation engine, whatever mode is selected. Adaptation therefore keeps running while the timing loop uses two-level slicing.

Top module: `mm_dual_pd`

## Requirements
- R1: While reset is high, and after it until the first accepted symbol, `adapt_vld_o` and `phase_vld_o` are low and `adapt_dec_o`, `adapt_err_o` and `phase_o` are zero.
- R2: Four-level slicing of sample x (two's complement) against reference r (unsigned) gives +3 if 3x >= 2r, else +1 if 3x >= 0, else -1 if 3x >= -2r, else -3. Decisions are encoded as signed 3-bit values.
- R3: The adaptation error is the sample minus the ideal level, expressed in thirds of a sample LSB: e = 3x - d·r. It appears on `adapt_err_o` together with `adapt_dec_o`, with `adapt_vld_o` high, on the clock edge after the one that accepts the symbol.
- R4: `adapt_dec_o` and `adapt_err_o` always carry the four-level result, in both modes.
- R5: With `mode_i` = 1 the timing computation uses two-level slicing: d = +3 if x >= 0, else -3. The error uses the same formula as R3. With `mode_i` = 0 it uses the four-level result.
- R6: For symbol t, `phase_o` = D(t-1)·E(t) - D(t)·E(t-1). It is valid (`phase_vld_o` high for one cycle) on the second clock edge after the edge that accepts symbol t.
- R7: The first symbol accepted after reset produces no phase output, because it has no predecessor.
- R8: The mode captured with symbol t applies to both operands of its phase word. The previous symbol is re-sliced in that mode, so no product ever mixes the two modes, including on the symbol where the mode changes.
- R9: Cycles with `valid_i` low are ignored. The previous symbol is retained across any gap, `adapt_vld_o` and `phase_vld_o` stay low, and `adapt_err_o` holds its value.
- R10: The phase word is exact for every combination of sample and reference, with no overflow or wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | A symbol sample is present this cycle |
| mode_i | input | 1 | 0: four-level timing slicing, 1: two-level timing slicing |
| sample_i | input | 8 | Equalized sample, two's complement |
| ref_i | input | 8 | Slicer reference (outer level amplitude), unsigned |
| adapt_vld_o | output | 1 | Adaptation outputs are valid |
| adapt_dec_o | output | 3 | Four-level decision, signed |
| adapt_err_o | output | 12 | Four-level error in thirds of an LSB, signed |
| phase_vld_o | output | 1 | Phase word is valid |
| phase_o | output | 15 | Mueller-Müller phase error, signed |

## Verification
The adaptation outputs are due one clock edge after the edge that accepts a symbol. The phase word is due one edge later. The bench drives inputs on the falling edge. It samples the adaptation results on the next falling edge and the phase word on the falling edge after that. For back-to-back symbols, each symbol's adaptation check overlaps the previous symbol's phase check. During idle gaps, the bench confirms at each falling edge that the valid flags are low and the error is held. The expected values are computed from the previous symbol's raw sample and reference, re-sliced in the current symbol's mode.

// File: rtl/pd_pkg.sv
package pd_pkg;

    localparam int SAMPLE_W = 8;
    localparam int REF_W    = 8;
    localparam int WIDE_W   = (SAMPLE_W > REF_W) ? SAMPLE_W : REF_W;
    // 3x plus 3r needs two bits above the wider input, plus sign and margin
    localparam int ERR_W    = WIDE_W + 4;
    // |d| <= 3 costs two bits, the difference of two products one more
    localparam int PH_W     = ERR_W + 3;

    typedef logic signed [2:0]       dec_t;
    typedef logic signed [ERR_W-1:0] err_t;
    typedef logic signed [PH_W-1:0]  ph_t;

    typedef enum logic {
        MODE_PAM4 = 1'b0,
        MODE_NRZ  = 1'b1
    } pd_mode_e;

    typedef struct packed {
        dec_t dec;
        err_t err;
    } sym_t;

    typedef struct packed {
        sym_t     four;
        sym_t     two;
        pd_mode_e mode;
    } slot_t;

    localparam dec_t DEC_P3 = 3'sd3;
    localparam dec_t DEC_P1 = 3'sd1;
    localparam dec_t DEC_M1 = -3'sd1;
    localparam dec_t DEC_M3 = -3'sd3;

    function automatic err_t ext_sample(input logic [SAMPLE_W-1:0] x);
        return err_t'({{(ERR_W-SAMPLE_W){x[SAMPLE_W-1]}}, x});
    endfunction

    function automatic err_t ext_ref(input logic [REF_W-1:0] r);
        return err_t'({{(ERR_W-REF_W){1'b0}}, r});
    endfunction

    function automatic ph_t ext_err(input err_t e);
        return ph_t'({{(PH_W-ERR_W){e[ERR_W-1]}}, e});
    endfunction

    // multiply by one of the four decision values using adds only
    function automatic err_t scale_err(input dec_t d, input err_t v);
        err_t r;
        case (d)
            DEC_P3:  r = v + v + v;
            DEC_P1:  r = v;
            DEC_M1:  r = -v;
            default: r = -(v + v + v);
        endcase
        return r;
    endfunction

    function automatic ph_t scale_ph(input dec_t d, input err_t e);
        ph_t v;
        ph_t r;
        v = ext_err(e);
        case (d)
            DEC_P3:  r = v + v + v;
            DEC_P1:  r = v;
            DEC_M1:  r = -v;
            default: r = -(v + v + v);
        endcase
        return r;
    endfunction

    function automatic sym_t slice(input logic [SAMPLE_W-1:0] x,
                                   input logic [REF_W-1:0]    r,
                                   input pd_mode_e            m);
        sym_t s;
        err_t xs;
        err_t x3;
        err_t rs;
        err_t thr_hi;
        err_t thr_lo;
        xs     = ext_sample(x);
        x3     = xs + xs + xs;
        rs     = ext_ref(r);
        thr_hi = rs + rs;
        thr_lo = -thr_hi;
        if (m == MODE_NRZ) begin
            s.dec = xs[ERR_W-1] ? DEC_M3 : DEC_P3;
        end else if (x3 >= thr_hi) begin
            s.dec = DEC_P3;
        end else if (!x3[ERR_W-1]) begin
            s.dec = DEC_P1;
        end else if (x3 >= thr_lo) begin
            s.dec = DEC_M1;
        end else begin
            s.dec = DEC_M3;
        end
        s.err = x3 - scale_err(s.dec, rs);
        return s;
    endfunction

endpackage

// File: rtl/pd_slicer.sv
module pd_slicer
    import pd_pkg::*;
#(
    parameter pd_mode_e MODE = MODE_PAM4
) (
    input  logic [SAMPLE_W-1:0] sample_i,
    input  logic [REF_W-1:0]    ref_i,
    output sym_t                sym_o
);

    always_comb begin
        sym_o = slice(sample_i, ref_i, MODE);
    end

endmodule

// File: rtl/pd_symbol_pipe.sv
module pd_symbol_pipe
    import pd_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  valid_i,
    input  slot_t slot_i,
    output slot_t cur_o,
    output slot_t prev_o,
    output logic  cur_vld_o,
    output logic  pair_ok_o
);

    logic seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_o     <= '0;
            prev_o    <= '0;
            cur_vld_o <= 1'b0;
            pair_ok_o <= 1'b0;
            seen_q    <= 1'b0;
        end else begin
            cur_vld_o <= valid_i;
            if (valid_i) begin
                prev_o    <= cur_o;
                cur_o     <= slot_i;
                pair_ok_o <= seen_q;
                seen_q    <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/pd_mm_core.sv
module pd_mm_core
    import pd_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  slot_t cur_i,
    input  slot_t prev_i,
    input  logic  cur_vld_i,
    input  logic  pair_ok_i,
    output ph_t   phase_o,
    output logic  phase_vld_o
);

    sym_t now_s;
    sym_t old_s;
    ph_t  phase_d;

    // both operands follow the mode captured with the current symbol
    always_comb begin
        if (cur_i.mode == MODE_NRZ) begin
            now_s = cur_i.two;
            old_s = prev_i.two;
        end else begin
            now_s = cur_i.four;
            old_s = prev_i.four;
        end
        phase_d = scale_ph(old_s.dec, now_s.err) - scale_ph(now_s.dec, old_s.err);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_o     <= '0;
            phase_vld_o <= 1'b0;
        end else begin
            phase_vld_o <= cur_vld_i & pair_ok_i;
            if (cur_vld_i && pair_ok_i) begin
                phase_o <= phase_d;
            end
        end
    end

endmodule

// File: rtl/mm_dual_pd.sv
module mm_dual_pd
    import pd_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    valid_i,
    input  logic                    mode_i,
    input  logic [SAMPLE_W-1:0]     sample_i,
    input  logic [REF_W-1:0]        ref_i,
    output logic                    adapt_vld_o,
    output logic signed [2:0]       adapt_dec_o,
    output logic signed [ERR_W-1:0] adapt_err_o,
    output logic                    phase_vld_o,
    output logic signed [PH_W-1:0]  phase_o
);

    localparam int N_MODES = 2;

    sym_t  sliced [N_MODES];
    slot_t new_slot;
    slot_t cur_slot;
    slot_t prev_slot;
    logic  cur_vld;
    logic  pair_ok;
    ph_t   phase_w;

    for (genvar g = 0; g < N_MODES; g++) begin : g_slice
        pd_slicer #(
            .MODE((g == 1) ? MODE_NRZ : MODE_PAM4)
        ) u_slicer (
            .sample_i(sample_i),
            .ref_i   (ref_i),
            .sym_o   (sliced[g])
        );
    end

    always_comb begin
        new_slot.four = sliced[0];
        new_slot.two  = sliced[1];
        new_slot.mode = mode_i ? MODE_NRZ : MODE_PAM4;
    end

    pd_symbol_pipe u_pipe (
        .clk      (clk),
        .rst      (rst),
        .valid_i  (valid_i),
        .slot_i   (new_slot),
        .cur_o    (cur_slot),
        .prev_o   (prev_slot),
        .cur_vld_o(cur_vld),
        .pair_ok_o(pair_ok)
    );

    pd_mm_core u_core (
        .clk        (clk),
        .rst        (rst),
        .cur_i      (cur_slot),
        .prev_i     (prev_slot),
        .cur_vld_i  (cur_vld),
        .pair_ok_i  (pair_ok),
        .phase_o    (phase_w),
        .phase_vld_o(phase_vld_o)
    );

    assign adapt_vld_o = cur_vld;
    assign adapt_dec_o = cur_slot.four.dec;
    assign adapt_err_o = cur_slot.four.err;
    assign phase_o     = phase_w;

endmodule

// File: rtl/pd_checker.sv
module pd_checker
    import pd_pkg::*;
(
    input logic                    clk,
    input logic                    rst,
    input logic                    valid_i,
    input logic                    adapt_vld_o,
    input logic signed [2:0]       adapt_dec_o,
    input logic signed [ERR_W-1:0] adapt_err_o,
    input logic                    phase_vld_o,
    input logic signed [PH_W-1:0]  phase_o
);

    localparam int ERR_MAX  = 3 * (2 ** (SAMPLE_W - 1)) + 3 * (2 ** REF_W - 1);
    localparam int PH_BOUND = 6 * ERR_MAX;

    // R3
    adapt_due_chk: assert property (@(posedge clk) disable iff (rst)
        valid_i |=> adapt_vld_o);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> (!adapt_vld_o && $stable(adapt_err_o)));

    // R6
    phase_order_chk: assert property (@(posedge clk) disable iff (rst)
        phase_vld_o |-> $past(adapt_vld_o));

    // R2
    dec_code_chk: assert property (@(posedge clk) disable iff (rst)
        adapt_vld_o |-> adapt_dec_o[0]);

    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        phase_vld_o |-> ((int'(phase_o) <= PH_BOUND) && (int'(phase_o) >= -PH_BOUND)));

endmodule

bind mm_dual_pd pd_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .valid_i    (valid_i),
    .adapt_vld_o(adapt_vld_o),
    .adapt_dec_o(adapt_dec_o),
    .adapt_err_o(adapt_err_o),
    .phase_vld_o(phase_vld_o),
    .phase_o    (phase_o)
);

// File: tb/mm_dual_pd_tb.sv
module mm_dual_pd_tb;
    import pd_pkg::*;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    valid = 1'b0;
    logic                    mode = 1'b0;
    logic [SAMPLE_W-1:0]     sample = '0;
    logic [REF_W-1:0]        rf = '0;
    logic                    adapt_vld;
    logic signed [2:0]       adapt_dec;
    logic signed [ERR_W-1:0] adapt_err;
    logic                    phase_vld;
    logic signed [PH_W-1:0]  phase;

    int checks = 0;
    int errors = 0;
    int prev_x = 0;
    int prev_r = 0;
    bit have_prev = 1'b0;

    always #4 clk = ~clk;

    mm_dual_pd u_dut (
        .clk        (clk),
        .rst        (rst),
        .valid_i    (valid),
        .mode_i     (mode),
        .sample_i   (sample),
        .ref_i      (rf),
        .adapt_vld_o(adapt_vld),
        .adapt_dec_o(adapt_dec),
        .adapt_err_o(adapt_err),
        .phase_vld_o(phase_vld),
        .phase_o    (phase)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int mdec(input int x, input int r, input bit nrz);
        if (nrz) return (x >= 0) ? 3 : -3;
        if (3 * x >= 2 * r) return 3;
        if (3 * x >= 0) return 1;
        if (3 * x >= -2 * r) return -1;
        return -3;
    endfunction

    function automatic int merr(input int x, input int r, input bit nrz);
        return 3 * x - mdec(x, r, nrz) * r;
    endfunction

    function automatic int mphase(input int x, input int r, input int px, input int pr, input bit nrz);
        return mdec(px, pr, nrz) * merr(x, r, nrz) - mdec(x, r, nrz) * merr(px, pr, nrz);
    endfunction

    task automatic drive(input int x, input int r, input bit nrz);
        sample = x[SAMPLE_W-1:0];
        rf     = r[REF_W-1:0];
        mode   = nrz;
        valid  = 1'b1;
    endtask

    task automatic chk_adapt(input int x, input int r);
        chk("R3 adapt_vld", int'(adapt_vld), 1);
        chk("R2 R4 adapt_dec", int'(adapt_dec), mdec(x, r, 1'b0));
        chk("R3 R4 adapt_err", int'(adapt_err), merr(x, r, 1'b0));
    endtask

    task automatic chk_phase(input int x, input int r, input bit nrz, input bit has_prev,
                             input int px, input int pr);
        chk("R6 R7 phase_vld", int'(phase_vld), int'(has_prev));
        if (has_prev) chk("R5 R6 R8 phase", int'(phase), mphase(x, r, px, pr, nrz));
    endtask

    // one symbol followed by one idle cycle
    task automatic send(input int x, input int r, input bit nrz);
        @(negedge clk);
        drive(x, r, nrz);
        @(negedge clk);
        valid = 1'b0;
        chk_adapt(x, r);
        @(negedge clk);
        chk_phase(x, r, nrz, have_prev, prev_x, prev_r);
        chk("R9 adapt_vld idle", int'(adapt_vld), 0);
        prev_x = x;
        prev_r = r;
        have_prev = 1'b1;
    endtask

    task automatic t_reset();
        chk("R1 adapt_vld", int'(adapt_vld), 0);
        chk("R1 phase_vld", int'(phase_vld), 0);
        chk("R1 adapt_err", int'(adapt_err), 0);
        chk("R1 adapt_dec", int'(adapt_dec), 0);
        chk("R1 phase", int'(phase), 0);
    endtask

    task automatic t_thresholds();
        int xs[8] = '{60, 59, 0, -1, -60, -61, 100, -100};
        foreach (xs[i]) send(xs[i], 90, 1'b0);
    endtask

    task automatic t_two_level();
        int xs[5] = '{20, -20, 50, -5, 0};
        foreach (xs[i]) send(xs[i], 90, 1'b1);
    endtask

    task automatic t_switch();
        send(30, 90, 1'b0);
        send(-25, 90, 1'b1);
        send(45, 80, 1'b0);
        send(-70, 80, 1'b1);
        send(10, 60, 1'b0);
    endtask

    task automatic t_back_to_back();
        int ax = 40, ar = 90, bx = -35, br = 90;
        bit am = 1'b0, bm = 1'b1;
        @(negedge clk);
        drive(ax, ar, am);
        @(negedge clk);
        chk_adapt(ax, ar);
        drive(bx, br, bm);
        @(negedge clk);
        valid = 1'b0;
        chk_adapt(bx, br);
        chk_phase(ax, ar, am, have_prev, prev_x, prev_r);
        @(negedge clk);
        chk_phase(bx, br, bm, 1'b1, ax, ar);
        prev_x = bx;
        prev_r = br;
        have_prev = 1'b1;
    endtask

    task automatic t_gap();
        int held;
        held = int'(adapt_err);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk("R9 gap adapt_vld", int'(adapt_vld), 0);
            chk("R9 gap phase_vld", int'(phase_vld), 0);
            chk("R9 gap adapt_err held", int'(adapt_err), held);
        end
        send(-15, 70, 1'b0);
    endtask

    task automatic t_extremes();
        send(127, 255, 1'b1);
        send(-128, 255, 1'b1);
        send(127, 255, 1'b1);
        send(-128, 0, 1'b0);
        send(127, 0, 1'b0);
        send(-128, 255, 1'b0);
        send(127, 255, 1'b0);
        send(-128, 0, 1'b1);
        chk("R10 last phase", int'(phase), mphase(-128, 0, 127, 255, 1'b1));
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_thresholds();
        t_two_level();
        t_switch();
        t_back_to_back();
        t_gap();
        t_extremes();
        summary();
    end

endmodule